// File: doc/BRIEF.md
# Cache-Line Block Copy Engine

This block moves data between two regions of memory in whole cache lines, with no processor involvement once it has been started. Software programs a line count, a source address, a destination address and a completion-word address into a small register set. A write to the control register starts the copy. The engine then reads one full line into an internal line buffer and writes that line out to the destination. It repeats this for each line in turn. When it has finished, it stores a 64-bit completion word at the software-chosen completion address.

Software typically preloads the completion word with all ones and waits for it to change. It can instead poll the length/status register until that register reads zero. A memory fault stops the copy early. The completion word then carries a set error flag together with a code that tells a read fault from a write fault. A soft-reset command abandons any copy in flight and returns the engine to idle.

The memory side has one request port, one 64-bit beat wide. A line of `LINE_BYTES` bytes takes `LINE_BYTES/8` beats.

Top module: `line_copy_engine`

## Requirements
- R1: After reset, register 0 (length/status) reads zero and no memory request is raised.
- R2: The engine copies each of the N programmed lines in ascending line order. For each line it reads the whole line from source, beats in ascending 8-byte steps, and then writes the whole line to destination, so that the destination holds an exact copy of the N source lines. Register map (by `reg_addr`): 0 length/status, 1 source, 2 destination, 3 completion address, 4 control, 5 reset. A write to register 4 while idle starts the engine.
- R3: The low log2(`LINE_BYTES`) bits of the source and destination registers are ignored, and the low 3 bits of the completion-address register are ignored.
- R4: The line count is taken from bits [LEN_W-1:0] of the value written to register 0. Bits from LEN_W to 62 have no effect.
- R5: Bit 63 of register 0 reads 1 from the cycle after the start until the completion write has been accepted, even if software wrote it as 0. After that, register 0 reads zero.
- R6: Writes to registers 0 to 4 while the engine is running are ignored. This covers both the copy and the values read back afterwards.
- R7: A line count of zero produces exactly one memory access: the completion write of a success word.
- R8: An error response on a read beat aborts the remaining beats and lines. The completion word is then 0x8000_0000_0000_0001 (bit 63 is the error flag, and the low byte 1 means read fault).
- R9: An error response on a write beat aborts the remaining beats and lines. The completion word is then 0x8000_0000_0000_0002 (low byte 2 means write fault).
- R10: Writing register 5 with bit 0 set drops any pending request from the next cycle onward and returns the engine to idle, with register 0 reading zero.
- R11: A memory request that has not been accepted holds its address and direction in the next cycle.
- R12: A copy with no fault completes by writing the value zero to the 8-byte-aligned completion address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for both write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read value of the register selected by `reg_addr` (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 64 | Write beat data |
| mem_ack | input | 1 | Memory accepts the current beat; read data and error are valid with it |
| mem_rdata | input | 64 | Read beat data |
| mem_err | input | 1 | Error response for the accepted beat |

## Verification
The assertions assume a memory that signals `mem_ack` only while `mem_req` is high, and `mem_err` only together with `mem_ack`. They also assume that register writes and the soft-reset command arrive as single-cycle strobes. The bench memory model derives its accept and error signals combinationally from the current request, gated by a stall mode (always accept, accept every other cycle, never accept). Faults are injected at one chosen word and direction, so error responses only ever come with an accepted beat. Every register access in the bench is a one-cycle strobe driven at the falling edge.

// File: rtl/lce_pkg.sv
package lce_pkg;

  localparam int unsigned LCE_DW        = 64;
  localparam int unsigned LCE_BEAT_SH   = 3;
  localparam int unsigned LCE_FLAG_BIT  = 63;

  typedef enum logic [2:0] {
    RA_LENSTAT = 3'd0,
    RA_SRC     = 3'd1,
    RA_DST     = 3'd2,
    RA_NTFY    = 3'd3,
    RA_CTRL    = 3'd4,
    RA_RESET   = 3'd5
  } lce_reg_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_READ,
    SQ_WRITE,
    SQ_NOTIFY
  } lce_state_e;

  typedef enum logic [7:0] {
    FC_NONE  = 8'd0,
    FC_READ  = 8'd1,
    FC_WRITE = 8'd2
  } lce_fault_e;

  // clear the low sh bits of an address
  function automatic logic [63:0] lce_align(input logic [63:0] a, input int unsigned sh);
    return a & ~((64'd1 << sh) - 64'd1);
  endfunction

  // byte address of one beat: aligned base + line offset + beat offset
  function automatic logic [63:0] lce_beat_addr(input logic [63:0] base,
                                                input logic [63:0] line,
                                                input logic [63:0] beat,
                                                input int unsigned line_sh);
    return lce_align(base, line_sh) + (line << line_sh) + (beat << LCE_BEAT_SH);
  endfunction

  // completion word: zero on success, flag bit plus fault code otherwise
  function automatic logic [63:0] lce_status(input lce_fault_e f);
    logic [63:0] w;
    w = 64'd0;
    if (f != FC_NONE) begin
      w[LCE_FLAG_BIT] = 1'b1;
      w[7:0]          = f;
    end
    return w;
  endfunction

endpackage

// File: rtl/lce_regfile.sv
module lce_regfile
  import lce_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              seq_active,
  input  logic              done_evt,
  output logic              start_evt,
  output logic              sreset_evt,
  output logic              lnst_busy_rd,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] ntfy_q,
  output logic [LEN_W-1:0]  cnt_q
);

  logic              busy_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_ok;
  logic              lint_unused_bits;

  assign lint_unused_bits = ^reg_wdata;

  // register writes only land while the sequencer is idle
  assign wr_ok        = reg_wr && !seq_active;
  assign sreset_evt   = reg_wr && (reg_addr == RA_RESET) && reg_wdata[0];
  assign start_evt    = wr_ok && (reg_addr == RA_CTRL);
  assign lnst_busy_rd = busy_q || seq_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      ntfy_q <= '0;
      mode_q <= '0;
    end else begin
      if (sreset_evt || done_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_evt) begin
        busy_q <= 1'b1;
      end else if (wr_ok && (reg_addr == RA_LENSTAT)) begin
        busy_q <= reg_wdata[LCE_FLAG_BIT];
        cnt_q  <= reg_wdata[LEN_W-1:0];
      end
      if (wr_ok && (reg_addr == RA_SRC))  src_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_ok && (reg_addr == RA_DST))  dst_q  <= reg_wdata[ADDR_W-1:0];
      if (wr_ok && (reg_addr == RA_NTFY)) ntfy_q <= reg_wdata[ADDR_W-1:0];
      if (start_evt)                      mode_q <= reg_wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_LENSTAT: begin
        reg_rdata[LCE_FLAG_BIT] = lnst_busy_rd;
        reg_rdata[LEN_W-1:0]    = cnt_q;
      end
      RA_SRC:  reg_rdata[ADDR_W-1:0] = src_q;
      RA_DST:  reg_rdata[ADDR_W-1:0] = dst_q;
      RA_NTFY: reg_rdata[ADDR_W-1:0] = ntfy_q;
      RA_CTRL: reg_rdata[MODE_W-1:0] = mode_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lce_seq.sv
module lce_seq
  import lce_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              sreset_evt,
  input  logic [LEN_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [ADDR_W-1:0] ntfy_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_err,
  output logic              seq_active,
  output logic              done_evt,
  output logic              err_evt
);

  localparam int unsigned BEATS   = LINE_BYTES / (LCE_DW / 8);
  localparam int unsigned BEAT_W  = $clog2(BEATS);
  localparam int unsigned LINE_SH = $clog2(LINE_BYTES);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  lce_state_e        st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [LEN_W-1:0]  line_q;
  lce_fault_e        fault_q;
  logic              last_line;
  logic              rd_fill;
  logic [BEATS-1:0][63:0] lbuf;

  assign last_line  = (line_q == cnt_q - LEN_W'(1));
  assign rd_fill    = (st_q == SQ_READ) && mem_ack && !mem_err;
  assign seq_active = (st_q != SQ_IDLE);
  assign done_evt   = (st_q == SQ_NOTIFY) && mem_ack;
  assign err_evt    = mem_ack && mem_err && ((st_q == SQ_READ) || (st_q == SQ_WRITE));

  // one line of storage, one register per beat
  for (genvar g = 0; g < BEATS; g++) begin : g_lbuf
    logic [63:0] ent_q;
    always_ff @(posedge clk) begin
      if (rd_fill && (beat_q == BEAT_W'(g))) ent_q <= mem_rdata;
    end
    assign lbuf[g] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      beat_q  <= '0;
      line_q  <= '0;
      fault_q <= FC_NONE;
    end else if (sreset_evt) begin
      st_q    <= SQ_IDLE;
      beat_q  <= '0;
      line_q  <= '0;
      fault_q <= FC_NONE;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_evt) begin
            beat_q  <= '0;
            line_q  <= '0;
            fault_q <= FC_NONE;
            st_q    <= (cnt_q == '0) ? SQ_NOTIFY : SQ_READ;
          end
        end
        SQ_READ: begin
          if (mem_ack) begin
            if (mem_err) begin
              fault_q <= FC_READ;
              st_q    <= SQ_NOTIFY;
            end else if (beat_q == LAST_BEAT) begin
              beat_q <= '0;
              st_q   <= SQ_WRITE;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end
        end
        SQ_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              fault_q <= FC_WRITE;
              st_q    <= SQ_NOTIFY;
            end else if (beat_q == LAST_BEAT) begin
              beat_q <= '0;
              if (last_line) begin
                st_q <= SQ_NOTIFY;
              end else begin
                line_q <= line_q + LEN_W'(1);
                st_q   <= SQ_READ;
              end
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end
        end
        SQ_NOTIFY: begin
          if (mem_ack) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = seq_active;
    mem_we    = (st_q == SQ_WRITE) || (st_q == SQ_NOTIFY);
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      SQ_READ:   mem_addr = ADDR_W'(lce_beat_addr(64'(src_q), 64'(line_q), 64'(beat_q), LINE_SH));
      SQ_WRITE: begin
        mem_addr  = ADDR_W'(lce_beat_addr(64'(dst_q), 64'(line_q), 64'(beat_q), LINE_SH));
        mem_wdata = lbuf[beat_q];
      end
      SQ_NOTIFY: begin
        mem_addr  = ADDR_W'(lce_align(64'(ntfy_q), LCE_BEAT_SH));
        mem_wdata = lce_status(fault_q);
      end
      default: begin
        mem_addr  = '0;
        mem_wdata = '0;
      end
    endcase
  end

endmodule

// File: rtl/line_copy_engine.sv
module line_copy_engine #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_err
);

  // internal events, named for the checker
  logic              start_evt;
  logic              sreset_evt;
  logic              done_evt;
  logic              err_evt;
  logic              seq_active;
  logic              lnst_busy_rd;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [ADDR_W-1:0] ntfy_q;
  logic [LEN_W-1:0]  cnt_q;

  lce_regfile #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .MODE_W (8)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .seq_active   (seq_active),
    .done_evt     (done_evt),
    .start_evt    (start_evt),
    .sreset_evt   (sreset_evt),
    .lnst_busy_rd (lnst_busy_rd),
    .src_q        (src_q),
    .dst_q        (dst_q),
    .ntfy_q       (ntfy_q),
    .cnt_q        (cnt_q)
  );

  lce_seq #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .sreset_evt (sreset_evt),
    .cnt_q      (cnt_q),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .ntfy_q     (ntfy_q),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_err    (mem_err),
    .seq_active (seq_active),
    .done_evt   (done_evt),
    .err_evt    (err_evt)
  );

endmodule

// File: rtl/line_copy_engine_chk.sv
module line_copy_engine_chk #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              start_evt,
  input logic              sreset_evt,
  input logic              err_evt,
  input logic              done_evt,
  input logic              seq_active,
  input logic              lnst_busy_rd,
  input logic [ADDR_W-1:0] src_q,
  input logic [ADDR_W-1:0] ntfy_q,
  input logic [LEN_W-1:0]  cnt_q
);

  logic [ADDR_W-1:0] ntfy_al;
  assign ntfy_al = {ntfy_q[ADDR_W-1:3], 3'b000};

  assert_busy_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> lnst_busy_rd);

  assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !lnst_busy_rd);

  assert_src_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && reg_wr && reg_addr == 3'd1) |=> $stable(src_q));

  assert_zero_count_notify_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cnt_q == '0) |=> (mem_req && mem_we && mem_addr == ntfy_al));

  assert_fault_notify_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !sreset_evt) |=> (mem_req && mem_we && mem_addr == ntfy_al));

  assert_sreset_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_evt |=> (!mem_req && !seq_active));

  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !sreset_evt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind line_copy_engine line_copy_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_line_copy_engine.sv
`timescale 1ns/1ps
module sim_line_copy_engine;

  localparam int AW  = 16;
  localparam int LW  = 8;
  localparam int WPL = 16;           // words per line
  localparam int NTW = 250;          // completion word index
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [63:0] mem [256];
  int  stall_mode = 0;
  int  fault_idx = -1;
  bit  fault_we = 0;
  int  acc = 0;
  logic [31:0] cyc = '0;
  logic [7:0]  widx;

  always #2.5 clk = ~clk;

  line_copy_engine #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(128)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  assign widx = mem_addr[10:3];
  assign mem_ack = mem_req && ((stall_mode == 0) || (stall_mode == 1 && cyc[0]));
  assign mem_rdata = mem[widx];
  assign mem_err = mem_ack && (int'(widx) == fault_idx) && (mem_we == fault_we);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_ack) acc <= acc + 1;
    if (mem_ack && mem_we && !mem_err) mem[widx] <= mem_wdata;
  end

  function automatic logic [63:0] pat(input int i);
    return {16'hC0DE, 16'(i), 32'(i * 40503 + 7)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    mem[NTW] = ONES;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start_copy(input int sb, input int db, input int nb, input logic [63:0] lenw);
    reg_write(3'd0, lenw);
    reg_write(3'd1, 64'(sb));
    reg_write(3'd2, 64'(db));
    reg_write(3'd3, 64'(nb));
    reg_write(3'd4, 64'h5);
  endtask

  task automatic wait_idle(output bit ok);
    logic [63:0] v;
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      reg_read(3'd0, v);
      if (v == 64'd0) begin ok = 1; break; end
    end
  endtask

  // mismatching words in n copied lines, src word sw -> dst word dw
  function automatic int copy_errs(input int sw, input int dw, input int n);
    int e = 0;
    for (int i = 0; i < n * WPL; i++) if (mem[dw + i] !== pat(sw + i)) e++;
    return e;
  endfunction

  function automatic int untouched_errs(input int dw, input int n);
    int e = 0;
    for (int i = 0; i < n * WPL; i++) if (mem[dw + i] !== pat(dw + i)) e++;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0x%016h expected=0x%016h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    bit ok;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_read(3'd0, v);
    check(v == 64'd0, "R1 lenstat after reset", v, 64'd0);
    check(mem_req == 1'b0, "R1 no request after reset", 64'(mem_req), 64'd0);

    // R2 / R11 / R12: sweep line counts, placements and stall patterns
    for (int sm = 0; sm < 2; sm++) begin
      for (int n = 1; n <= 3; n++) begin
        for (int k = 0; k < 3; k++) begin
          stall_mode = sm;
          init_mem();
          start_copy(k * 128, (8 + k) * 128, NTW * 8, 64'(n));
          wait_idle(ok);
          check(ok, "R2 copy completes", 64'(ok), 64'd1);
          check(copy_errs(k * WPL, (8 + k) * WPL, n) == 0, "R2/R11 destination matches source",
                64'(copy_errs(k * WPL, (8 + k) * WPL, n)), 64'd0);
          check(untouched_errs((8 + k + n) * WPL, 1) == 0, "R2 line after destination untouched",
                64'(untouched_errs((8 + k + n) * WPL, 1)), 64'd0);
          check(mem[NTW] == 64'd0, "R12 success word", mem[NTW], 64'd0);
        end
      end
    end
    stall_mode = 0;

    // R3: misaligned register values behave as aligned
    init_mem();
    start_copy(2 * 128 + 8'h45, 9 * 128 + 8'h7F, NTW * 8 + 5, 64'd1);
    wait_idle(ok);
    check(copy_errs(2 * WPL, 9 * WPL, 1) == 0, "R3 low address bits ignored",
          64'(copy_errs(2 * WPL, 9 * WPL, 1)), 64'd0);
    check(mem[NTW] == 64'd0, "R3 notify low bits ignored", mem[NTW], 64'd0);

    // R4: count bits above the length field ignored
    init_mem();
    start_copy(0, 8 * 128, NTW * 8, (64'd1 << LW) | 64'd2);
    wait_idle(ok);
    check(copy_errs(0, 8 * WPL, 2) == 0, "R4 two lines copied", 64'(copy_errs(0, 8 * WPL, 2)), 64'd0);
    check(untouched_errs(10 * WPL, 1) == 0, "R4 third line untouched", 64'(untouched_errs(10 * WPL, 1)), 64'd0);

    // R5: busy visible while running even when written clear
    init_mem();
    stall_mode = 1;
    start_copy(0, 8 * 128, NTW * 8, 64'd1);
    reg_read(3'd0, v);
    check(v[63] == 1'b1, "R5 busy while running", v, 64'h8000_0000_0000_0001);
    wait_idle(ok);
    reg_read(3'd0, v);
    check(ok && v == 64'd0, "R5 lenstat zero after completion", v, 64'd0);

    // R6: writes while running ignored
    init_mem();
    start_copy(0, 8 * 128, NTW * 8, 64'd2);
    reg_write(3'd1, 64'(3 * 128));
    reg_write(3'd2, 64'(12 * 128));
    reg_write(3'd3, 64'(100 * 8));
    reg_write(3'd0, 64'd5);
    wait_idle(ok);
    reg_read(3'd1, v);
    check(v == 64'd0, "R6 source register unchanged", v, 64'd0);
    reg_read(3'd2, v);
    check(v == 64'(8 * 128), "R6 destination register unchanged", v, 64'(8 * 128));
    check(copy_errs(0, 8 * WPL, 2) == 0 && untouched_errs(12 * WPL, 2) == 0,
          "R6 copy used original settings", 64'(copy_errs(0, 8 * WPL, 2)), 64'd0);
    check(mem[NTW] == 64'd0 && mem[100] == pat(100), "R6 notify at original address", mem[NTW], 64'd0);
    stall_mode = 0;

    // R7: zero count
    init_mem();
    start_copy(0, 8 * 128, NTW * 8, 64'd0);
    @(negedge clk);
    acc = 0;
    reg_write(3'd4, 64'h5);
    wait_idle(ok);
    check(mem[NTW] == 64'd0, "R7 zero count success word", mem[NTW], 64'd0);
    check(acc == 1, "R7 single memory access", 64'(acc), 64'd1);
    check(untouched_errs(8 * WPL, 1) == 0, "R7 destination untouched", 64'(untouched_errs(8 * WPL, 1)), 64'd0);

    // R8: read fault in line 1 beat 5
    init_mem();
    fault_idx = WPL + 5; fault_we = 0;
    start_copy(0, 8 * 128, NTW * 8, 64'd3);
    wait_idle(ok);
    check(mem[NTW] == 64'h8000_0000_0000_0001, "R8 read fault word", mem[NTW], 64'h8000_0000_0000_0001);
    check(copy_errs(0, 8 * WPL, 1) == 0 && untouched_errs(9 * WPL, 2) == 0,
          "R8 abort after line 0", 64'(untouched_errs(9 * WPL, 2)), 64'd0);

    // R9: write fault in line 1 beat 2
    init_mem();
    fault_idx = 9 * WPL + 2; fault_we = 1;
    start_copy(0, 8 * 128, NTW * 8, 64'd3);
    wait_idle(ok);
    check(mem[NTW] == 64'h8000_0000_0000_0002, "R9 write fault word", mem[NTW], 64'h8000_0000_0000_0002);
    check(copy_errs(0, 8 * WPL, 1) == 0 && untouched_errs(10 * WPL, 1) == 0,
          "R9 abort in line 1", 64'(untouched_errs(10 * WPL, 1)), 64'd0);
    fault_idx = -1;

    // R10: soft reset while a request is stuck
    init_mem();
    stall_mode = 2;
    start_copy(0, 8 * 128, NTW * 8, 64'd1);
    repeat (5) @(negedge clk);
    check(mem_req == 1'b1, "R10 request pending before soft reset", 64'(mem_req), 64'd1);
    reg_write(3'd5, 64'd1);
    #1;
    check(mem_req == 1'b0, "R10 request dropped", 64'(mem_req), 64'd0);
    reg_read(3'd0, v);
    check(v == 64'd0, "R10 lenstat zero after soft reset", v, 64'd0);
    stall_mode = 0;
    init_mem();
    start_copy(1 * 128, 9 * 128, NTW * 8, 64'd1);
    wait_idle(ok);
    check(copy_errs(WPL, 9 * WPL, 1) == 0 && mem[NTW] == 64'd0, "R10 engine usable after soft reset",
          64'(copy_errs(WPL, 9 * WPL, 1)), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule